// File: doc/BRIEF.md
# Keyboard Event Interrupt Controller

This block sits between a keyboard front end and a small processor core. Each key press or key release is written into memory as two words: a status word that records the event kind and the modifier keys, and a keycode word. The block can then vector the core to a software handler. Software points the block at its mailbox and handlers by loading a descriptor. The descriptor holds a status address, a keycode address, a handler for presses and a handler for releases. A handler address of zero switches off the interrupt for that event kind.

Interrupt entry is carried out by the block. It stores the core's instruction pointer at the stack pointer, moves the stack pointer up by two, and redirects the core to the handler. It also wakes the core if it is halted and masks further entries. When the core signals a return from interrupt, the block reads the saved word at the stack pointer minus two and redirects the core back to it. It lowers the stack pointer by two and unmasks entries. Events that arrive while a sequence is running wait in a small queue.

Top module: `kbd_irq_ctrl`

## Requirements
- R1: After reset the block issues no memory access and no redirect, `irq_enabled` is 1 (parameter default) and `evt_overflow` is 0.
- R2: Events that arrive before the first `desc_load`, or in the same cycle as it, are discarded and cause no memory write.
- R3: In the second cycle after an event is sampled on an idle block, the block writes the status word to the status address. Bit 0 of that word is 1 for a release and 0 for a press. Bits 4:1 copy `evt_mods` (bit 0 shift, bit 1 ctrl, bit 2 alt, bit 3 altgr) and the upper bits are zero.
- R4: In the cycle after the status write, the block writes the keycode, zero-extended, to the keycode address.
- R5: A press vectors to the press handler and a release vectors to the release handler.
- R6: If interrupts are enabled and the selected handler is non-zero, entry follows in the cycle after the keycode write. In that cycle the block writes `core_ip` to address `core_sp` and pulses `pc_load` and `wake` with `pc_value` set to the handler and `sp_value` = `core_sp`+2. `irq_enabled` is 0 from the next cycle.
- R7: With interrupts disabled, both writes still happen but no entry takes place.
- R8: A `reti` pulse is served once the block is idle, ahead of queued events. The block issues a read at `core_sp`-2. In the next cycle it pulses `pc_load` with `pc_value` = `mem_rdata` and `sp_value` = `core_sp`-2, and `irq_enabled` is 1 from the cycle after that.
- R9: A handler address of zero produces the writes but no entry.
- R10: Up to 4 events wait in a queue. An event that arrives while 4 are held is dropped, and `evt_overflow` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_load | input | 1 | Load the four descriptor words |
| desc_status_ptr | input | AW | Address the status word is written to |
| desc_key_ptr | input | AW | Address the keycode is written to |
| desc_press_vec | input | AW | Press handler, 0 disables |
| desc_release_vec | input | AW | Release handler, 0 disables |
| evt_valid | input | 1 | Key event present this cycle |
| evt_release | input | 1 | 1 for release, 0 for press |
| evt_mods | input | 4 | Modifier keys: shift, ctrl, alt, altgr |
| evt_key | input | KEY_W | Keycode |
| reti | input | 1 | Return-from-interrupt request |
| core_ip | input | AW | Core instruction pointer |
| core_sp | input | AW | Core stack pointer |
| mem_rdata | input | AW | Read data, valid the cycle after `mem_re` |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | AW | Memory write data |
| pc_load | output | 1 | Redirect core: load `pc_value` and `sp_value` |
| pc_value | output | AW | New instruction pointer |
| sp_value | output | AW | New stack pointer |
| wake | output | 1 | Clear the core's halted state |
| irq_enabled | output | 1 | Interrupt entries allowed |
| evt_overflow | output | 1 | Sticky queue overflow flag |

## Verification
The bench targets the edge cycles of this block. It sends events before and during the descriptor load, which a design that armed itself too early would write to memory. It sends a return request in the middle of a burst, which a design with the wrong priority would serve after queued events, so the stack would unwind at the wrong moment. It sends a burst that fills the queue while the queue is being drained, and a design that checks for a full queue after the pop would accept a fifth event without flagging overflow. It also raises a release whose handler is zero, which a design that checked only the enable would take as an entry to address zero.

// File: rtl/kbd_irq_pkg.sv
package kbd_irq_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_STAT,
      PH_KEY,
      PH_ENTRY,
      PH_RDRET,
      PH_LDRET
   } phase_e;

   localparam int MOD_BITS = 4;
endpackage

// File: rtl/kbd_evt_fifo.sv
module kbd_evt_fifo #(
   parameter int W     = 21,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         dropped
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 2) else $error("kbd_evt_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  store_q [DEPTH];
   logic [PW-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt_q;
   logic          full, do_push, do_pop;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign dropped = push & full;
   assign dout    = store_q[rd_ptr_q];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr_q + PW'(1);
         assign rd_nxt = rd_ptr_q + PW'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + PW'(1);
         assign rd_nxt = (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) store_q[wr_ptr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (do_push) wr_ptr_q <= wr_nxt;
         if (do_pop)  rd_ptr_q <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R10
   full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);

   // R10
   drop_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dropped |-> !empty);
endmodule

// File: rtl/kbd_status_fmt.sv
module kbd_status_fmt #(
   parameter int DW = 16
) (
   input  logic                               release_evt,
   input  logic [kbd_irq_pkg::MOD_BITS-1:0]   mods,
   output logic [DW-1:0]                      status
);
   initial begin
      assert (DW > kbd_irq_pkg::MOD_BITS) else $error("kbd_status_fmt: DW too narrow");
   end

   always_comb begin
      status                             = '0;
      status[0]                          = release_evt;
      status[kbd_irq_pkg::MOD_BITS:1]    = mods;
   end
endmodule

// File: rtl/kbd_irq_seq.sv
module kbd_irq_seq
   import kbd_irq_pkg::*;
#(
   parameter int   AW           = 16,
   parameter int   KEY_W        = 16,
   parameter logic INT_EN_RESET = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ev_avail,
   input  logic                ev_release,
   input  logic [MOD_BITS-1:0] ev_mods,
   input  logic [KEY_W-1:0]    ev_key,
   output logic                ev_pop,
   input  logic                reti,
   input  logic [AW-1:0]       status_ptr,
   input  logic [AW-1:0]       key_ptr,
   input  logic [AW-1:0]       press_vec,
   input  logic [AW-1:0]       release_vec,
   input  logic [AW-1:0]       core_ip,
   input  logic [AW-1:0]       core_sp,
   input  logic [AW-1:0]       mem_rdata,
   output logic                mem_we,
   output logic                mem_re,
   output logic [AW-1:0]       mem_addr,
   output logic [AW-1:0]       mem_wdata,
   output logic                pc_load,
   output logic [AW-1:0]       pc_value,
   output logic [AW-1:0]       sp_value,
   output logic                wake,
   output logic                irq_en
);
   initial begin
      assert (KEY_W <= AW) else $error("kbd_irq_seq: KEY_W wider than AW");
   end

   phase_e              phase_q;
   logic                irq_en_q, ret_pend_q, take_ret, enter;
   logic                cur_rel_q;
   logic [MOD_BITS-1:0] cur_mods_q;
   logic [KEY_W-1:0]    cur_key_q;
   logic [AW-1:0]       handler, status_word;

   kbd_status_fmt #(.DW(AW)) u_fmt (
      .release_evt (cur_rel_q),
      .mods        (cur_mods_q),
      .status      (status_word)
   );

   assign take_ret = (phase_q == PH_IDLE) & ret_pend_q;
   assign ev_pop   = (phase_q == PH_IDLE) & ~ret_pend_q & ev_avail;
   assign handler  = cur_rel_q ? release_vec : press_vec;
   assign enter    = irq_en_q & (handler != '0);
   assign irq_en   = irq_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         irq_en_q   <= INT_EN_RESET;
         ret_pend_q <= 1'b0;
         cur_rel_q  <= 1'b0;
         cur_mods_q <= '0;
         cur_key_q  <= '0;
      end else begin
         ret_pend_q <= (ret_pend_q & ~take_ret) | reti;
         unique case (phase_q)
            PH_IDLE: begin
               if (take_ret) begin
                  phase_q <= PH_RDRET;
               end else if (ev_avail) begin
                  phase_q    <= PH_STAT;
                  cur_rel_q  <= ev_release;
                  cur_mods_q <= ev_mods;
                  cur_key_q  <= ev_key;
               end
            end
            PH_STAT:  phase_q <= PH_KEY;
            PH_KEY:   phase_q <= enter ? PH_ENTRY : PH_IDLE;
            PH_ENTRY: begin
               phase_q  <= PH_IDLE;
               irq_en_q <= 1'b0;
            end
            PH_RDRET: phase_q <= PH_LDRET;
            PH_LDRET: begin
               phase_q  <= PH_IDLE;
               irq_en_q <= 1'b1;
            end
            default:  phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      pc_load   = 1'b0;
      pc_value  = '0;
      sp_value  = '0;
      wake      = 1'b0;
      unique case (phase_q)
         PH_STAT: begin
            mem_we    = 1'b1;
            mem_addr  = status_ptr;
            mem_wdata = status_word;
         end
         PH_KEY: begin
            mem_we    = 1'b1;
            mem_addr  = key_ptr;
            mem_wdata = AW'(cur_key_q);
         end
         PH_ENTRY: begin
            mem_we    = 1'b1;
            mem_addr  = core_sp;
            mem_wdata = core_ip;
            pc_load   = 1'b1;
            pc_value  = handler;
            sp_value  = core_sp + AW'(2);
            wake      = 1'b1;
         end
         PH_RDRET: begin
            mem_re   = 1'b1;
            mem_addr = core_sp - AW'(2);
         end
         PH_LDRET: begin
            pc_load  = 1'b1;
            pc_value = mem_rdata;
            sp_value = core_sp - AW'(2);
         end
         default: ;
      endcase
   end

   // R6
   entry_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (mem_we && pc_load && pc_value != '0));

   // R6
   mask_after_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !irq_en);

   // R7
   entry_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> irq_en);

   // R8
   unmask_after_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && !wake) |=> irq_en);

   // R8
   read_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> (pc_load && !wake));

   // R3
   one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));
endmodule

// File: rtl/kbd_irq_ctrl.sv
module kbd_irq_ctrl
   import kbd_irq_pkg::*;
#(
   parameter int   AW           = 16,
   parameter int   KEY_W        = 16,
   parameter int   QDEPTH       = 4,
   parameter logic INT_EN_RESET = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                desc_load,
   input  logic [AW-1:0]       desc_status_ptr,
   input  logic [AW-1:0]       desc_key_ptr,
   input  logic [AW-1:0]       desc_press_vec,
   input  logic [AW-1:0]       desc_release_vec,
   input  logic                evt_valid,
   input  logic                evt_release,
   input  logic [3:0]          evt_mods,
   input  logic [KEY_W-1:0]    evt_key,
   input  logic                reti,
   input  logic [AW-1:0]       core_ip,
   input  logic [AW-1:0]       core_sp,
   input  logic [AW-1:0]       mem_rdata,
   output logic                mem_we,
   output logic                mem_re,
   output logic [AW-1:0]       mem_addr,
   output logic [AW-1:0]       mem_wdata,
   output logic                pc_load,
   output logic [AW-1:0]       pc_value,
   output logic [AW-1:0]       sp_value,
   output logic                wake,
   output logic                irq_enabled,
   output logic                evt_overflow
);
   localparam int EW = KEY_W + MOD_BITS + 1;

   logic [AW-1:0] status_ptr_q, key_ptr_q, press_vec_q, release_vec_q;
   logic          loaded_q, ovf_q;
   logic          q_empty, q_drop, q_pop;
   logic [EW-1:0] q_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_ptr_q  <= '0;
         key_ptr_q     <= '0;
         press_vec_q   <= '0;
         release_vec_q <= '0;
         loaded_q      <= 1'b0;
         ovf_q         <= 1'b0;
      end else begin
         if (desc_load) begin
            status_ptr_q  <= desc_status_ptr;
            key_ptr_q     <= desc_key_ptr;
            press_vec_q   <= desc_press_vec;
            release_vec_q <= desc_release_vec;
            loaded_q      <= 1'b1;
         end
         if (q_drop) ovf_q <= 1'b1;
      end
   end

   kbd_evt_fifo #(.W(EW), .DEPTH(QDEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (evt_valid & loaded_q),
      .din     ({evt_release, evt_mods, evt_key}),
      .pop     (q_pop),
      .dout    (q_out),
      .empty   (q_empty),
      .dropped (q_drop)
   );

   kbd_irq_seq #(.AW(AW), .KEY_W(KEY_W), .INT_EN_RESET(INT_EN_RESET)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_avail    (~q_empty),
      .ev_release  (q_out[EW-1]),
      .ev_mods     (q_out[EW-2:KEY_W]),
      .ev_key      (q_out[KEY_W-1:0]),
      .ev_pop      (q_pop),
      .reti        (reti),
      .status_ptr  (status_ptr_q),
      .key_ptr     (key_ptr_q),
      .press_vec   (press_vec_q),
      .release_vec (release_vec_q),
      .core_ip     (core_ip),
      .core_sp     (core_sp),
      .mem_rdata   (mem_rdata),
      .mem_we      (mem_we),
      .mem_re      (mem_re),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .pc_load     (pc_load),
      .pc_value    (pc_value),
      .sp_value    (sp_value),
      .wake        (wake),
      .irq_en      (irq_enabled)
   );

   assign evt_overflow = ovf_q;

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_overflow |=> evt_overflow);

   // R2
   no_write_unloaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !loaded_q |-> !mem_we);
endmodule

// File: tb/kbd_irq_ctrl_tb.sv
`timescale 1ns/1ps
module kbd_irq_ctrl_tb_top;
   localparam int QD = 4;
   localparam int P_IDLE = 0, P_STAT = 1, P_KEY = 2, P_ENTRY = 3, P_RD = 4, P_LD = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        desc_load = 1'b0;
   logic [15:0] d_stat = '0, d_key = '0, d_press = '0, d_rel = '0;
   logic        evt_valid = 1'b0, evt_release = 1'b0;
   logic [3:0]  evt_mods = '0;
   logic [15:0] evt_key = '0;
   logic        reti = 1'b0;
   logic [15:0] core_ip, core_sp, rdata;
   logic        mem_we, mem_re, pc_load, wake, irq_enabled, evt_overflow;
   logic [15:0] mem_addr, mem_wdata, pc_value, sp_value;

   always #2 clk = ~clk;

   kbd_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .desc_load(desc_load),
      .desc_status_ptr(d_stat), .desc_key_ptr(d_key),
      .desc_press_vec(d_press), .desc_release_vec(d_rel),
      .evt_valid(evt_valid), .evt_release(evt_release), .evt_mods(evt_mods),
      .evt_key(evt_key), .reti(reti), .core_ip(core_ip), .core_sp(core_sp),
      .mem_rdata(rdata), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .pc_load(pc_load), .pc_value(pc_value),
      .sp_value(sp_value), .wake(wake), .irq_enabled(irq_enabled),
      .evt_overflow(evt_overflow)
   );

   typedef struct packed {
      logic        rel;
      logic [3:0]  mods;
      logic [15:0] key;
   } ev_t;

   ev_t         mq[$];
   ev_t         mcur;
   int          mph;
   logic        m_loaded, m_ien, m_ovf, m_pend;
   logic [15:0] m_stat, m_key, m_press, m_rel;
   logic [15:0] mmem [logic [15:0]];
   int          n_chk = 0, n_fail = 0, wake_cnt = 0, we_cnt = 0;
   logic [15:0] last_wake_pc = '0;

   // Behavioural reference: one model step per rising edge.
   always @(posedge clk) begin : model
      logic [15:0] hnd;
      logic        do_push, take;
      ev_t         nev;
      if (!rst_n) begin
         mq.delete();
         mph = P_IDLE; mcur = '0;
         m_loaded = 1'b0; m_ien = 1'b1; m_ovf = 1'b0; m_pend = 1'b0;
         m_stat = '0; m_key = '0; m_press = '0; m_rel = '0;
         core_ip <= 16'h0040; core_sp <= 16'h0300; rdata <= '0;
      end else begin
         hnd     = mcur.rel ? m_rel : m_press;
         nev     = '{rel: evt_release, mods: evt_mods, key: evt_key};
         do_push = evt_valid && m_loaded && (mq.size() < QD);
         if (evt_valid && m_loaded && mq.size() >= QD) m_ovf = 1'b1;
         take    = (mph == P_IDLE) && m_pend;
         case (mph)
            P_IDLE: begin
               if (take) mph = P_RD;
               else if (mq.size() > 0) begin mcur = mq.pop_front(); mph = P_STAT; end
            end
            P_STAT: mph = P_KEY;
            P_KEY:  mph = (m_ien && hnd != 0) ? P_ENTRY : P_IDLE;
            P_ENTRY: begin
               mmem[core_sp] = core_ip;
               core_ip <= hnd; core_sp <= core_sp + 16'd2;
               m_ien = 1'b0; mph = P_IDLE;
            end
            P_RD: begin
               rdata <= mmem.exists(core_sp - 16'd2) ? mmem[core_sp - 16'd2] : 16'h0;
               mph = P_LD;
            end
            P_LD: begin
               core_ip <= rdata; core_sp <= core_sp - 16'd2;
               m_ien = 1'b1; mph = P_IDLE;
            end
            default: mph = P_IDLE;
         endcase
         if (do_push) mq.push_back(nev);
         m_pend = (m_pend && !take) || reti;
         if (desc_load) begin
            m_stat = d_stat; m_key = d_key; m_press = d_press; m_rel = d_rel;
            m_loaded = 1'b1;
         end
      end
   end

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Per-cycle comparison against the model, away from the rising edge.
   always @(negedge clk) begin : compare
      logic        e_we, e_re, e_pcl, e_wake;
      logic [15:0] e_addr, e_wd, e_pc, e_sp, hnd;
      string       tag;
      if (rst_n) begin
         hnd = mcur.rel ? m_rel : m_press;
         e_we = 0; e_re = 0; e_pcl = 0; e_wake = 0;
         e_addr = 0; e_wd = 0; e_pc = 0; e_sp = 0;
         tag = "R2";
         case (mph)
            P_STAT:  begin tag = "R3"; e_we = 1; e_addr = m_stat;
                        e_wd = {11'h0, mcur.mods, mcur.rel}; end
            P_KEY:   begin tag = "R4"; e_we = 1; e_addr = m_key; e_wd = mcur.key; end
            P_ENTRY: begin tag = "R6"; e_we = 1; e_addr = core_sp; e_wd = core_ip;
                        e_pcl = 1; e_wake = 1; e_pc = hnd; e_sp = core_sp + 16'd2; end
            P_RD:    begin tag = "R8"; e_re = 1; e_addr = core_sp - 16'd2; end
            P_LD:    begin tag = "R8"; e_pcl = 1; e_pc = rdata; e_sp = core_sp - 16'd2; end
            default: ;
         endcase
         chk(tag, "mem_we", 32'(mem_we), 32'(e_we));
         chk(tag, "mem_re", 32'(mem_re), 32'(e_re));
         chk(tag, "pc_load", 32'(pc_load), 32'(e_pcl));
         chk(tag, "wake", 32'(wake), 32'(e_wake));
         if (e_we || e_re) chk(tag, "mem_addr", 32'(mem_addr), 32'(e_addr));
         if (e_we) chk(tag, "mem_wdata", 32'(mem_wdata), 32'(e_wd));
         if (e_pcl) begin
            chk(tag, "pc_value", 32'(pc_value), 32'(e_pc));
            chk(tag, "sp_value", 32'(sp_value), 32'(e_sp));
         end
         chk("R7", "irq_enabled", 32'(irq_enabled), 32'(m_ien));
         chk("R10", "evt_overflow", 32'(evt_overflow), 32'(m_ovf));
         if (wake) begin wake_cnt++; last_wake_pc = pc_value; end
         if (mem_we) we_cnt++;
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(logic rel, logic [3:0] mods, logic [15:0] key);
      @(negedge clk);
      evt_valid = 1'b1; evt_release = rel; evt_mods = mods; evt_key = key;
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic load(logic [15:0] s, logic [15:0] k, logic [15:0] p, logic [15:0] r);
      @(negedge clk);
      desc_load = 1'b1; d_stat = s; d_key = k; d_press = p; d_rel = r;
      @(negedge clk);
      desc_load = 1'b0;
   endtask

   task automatic pulse_reti();
      @(negedge clk);
      reti = 1'b1;
      @(negedge clk);
      reti = 1'b0;
   endtask

   task automatic finish_run();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin : stimulus
      int w0;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk("R1", "mem_we", 32'(mem_we), 0);
      chk("R1", "pc_load", 32'(pc_load), 0);
      chk("R1", "irq_enabled", 32'(irq_enabled), 1);
      chk("R1", "evt_overflow", 32'(evt_overflow), 0);
      // R2 events before any descriptor
      send(1'b0, 4'h3, 16'h0011);
      step(8);
      chk("R2", "writes before load", 32'(we_cnt), 0);
      // R2 event in the same cycle as the load
      @(negedge clk);
      desc_load = 1'b1; d_stat = 16'h0100; d_key = 16'h0102;
      d_press = 16'h0200; d_rel = 16'h0280;
      evt_valid = 1'b1; evt_key = 16'h0022;
      @(negedge clk);
      desc_load = 1'b0; evt_valid = 1'b0;
      step(8);
      chk("R2", "writes for event during load", 32'(we_cnt), 0);
      // R5 R6 press with handler
      send(1'b0, 4'b0101, 16'h001c);
      step(8);
      chk("R5", "press handler", 32'(last_wake_pc), 32'h0200);
      chk("R6", "wake count", 32'(wake_cnt), 1);
      chk("R6", "masked after entry", 32'(irq_enabled), 0);
      // R7 release while masked
      w0 = we_cnt;
      send(1'b1, 4'b1010, 16'h001c);
      step(8);
      chk("R7", "no entry while masked", 32'(wake_cnt), 1);
      chk("R7", "writes while masked", 32'(we_cnt - w0), 2);
      // R8 return
      pulse_reti();
      step(6);
      chk("R8", "unmasked after return", 32'(irq_enabled), 1);
      chk("R8", "ip restored", 32'(core_ip), 32'h0040);
      // R5 release handler
      send(1'b1, 4'b1111, 16'h0045);
      step(8);
      chk("R5", "release handler", 32'(last_wake_pc), 32'h0280);
      pulse_reti();
      step(6);
      // R9 zero release handler
      load(16'h0110, 16'h0112, 16'h0200, 16'h0000);
      send(1'b1, 4'b0001, 16'h0050);
      step(8);
      chk("R9", "no entry for zero handler", 32'(wake_cnt), 2);
      chk("R9", "still enabled", 32'(irq_enabled), 1);
      // R10 burst with return request in the middle
      @(negedge clk);
      for (int i = 0; i < 7; i++) begin
         evt_valid = 1'b1; evt_release = 1'b0; evt_mods = 4'(i);
         evt_key = 16'h0060 + 16'(i);
         reti = (i == 4);
         @(negedge clk);
      end
      evt_valid = 1'b0; reti = 1'b0;
      step(60);
      chk("R10", "overflow flagged", 32'(evt_overflow), 1);
      step(4);
      chk("R10", "overflow sticky", 32'(evt_overflow), 1);
      finish_run();
   end
endmodule